// File: doc/BRIEF.md
# Decrementing BCD On-Delay Timer

This block is a ladder-logic style on-delay timer. While its enable condition is held active, it counts a four-digit decimal present value down from a set value. It takes one step per time-base period. The output flag rises once the count is exhausted, so the delay is the set value multiplied by the selected base. Two bases are available: a coarse base of 0.1 s and a fine base of 0.01 s. A clock-cycle prescaler generates both from a parameter that gives the number of clock cycles in 0.01 s. The coarse base is ten of those periods.

The set value either comes from a live input, or is fixed by a parameter when the build selects that variant. While the timer is idle, the present value follows the current set value. Each new timing run therefore uses whatever value the variable holds when enable rises. The set value and the present value are both held as packed BCD, four digits of four bits each, with the least significant digit in bits 3:0. A digit above nine is rejected: an error flag is raised and the timer does not run. Dropping enable, or pulsing the clear input, puts the timer back to its idle state. The next run then starts a full delay from the beginning.

Top module: `bcd_ondelay_timer`

## Requirements
- R1: While rst_n is low, done, pv and sv_err are all zero. The reset is applied asynchronously and released through a two-stage synchronizer.
- R2: While en is low, pv equals the selected set value and done is low. Both show this one clock after the set value is applied.
- R3: With fast=1, done rises exactly SV*CLK_PER_CENTI clock edges after en is first sampled high, for SV of 1 or more.
- R4: With fast=0, done rises exactly SV*CLK_PER_CENTI*10 clock edges after en is first sampled high, for SV of 1 or more.
- R5: pv decreases by exactly one decimal count per time-base period, with borrow across digits (for example 0100 becomes 0099). It never increases while the timer runs, and every digit stays in the range 0 to 9.
- R6: A set value of 0000 raises done after one time-base period of enable.
- R7: Once done is high, it stays high and pv stays at 0000 for as long as en stays high and clr stays low.
- R8: A one-cycle pulse on clr while running reloads pv with the set value and clears done. Timing then restarts, and a full delay is needed from the first edge after clr falls.
- R9: When en falls, done clears and pv reloads the set value on the next clock edge.
- R10: A change of sv_in during a run has no effect on the current count. The new value is used by the next run.
- R11: If any digit of the selected set value is above 9, then on the next edge sv_err is high, pv is 0000, done is low, and no counting takes place.
- R12: With SV_LIVE=0, the timer uses SV_FIXED and ignores sv_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timing condition; the timer runs while this is high |
| clr | input | 1 | Clear; returns the timer to the idle state while high |
| fast | input | 1 | Time base select: 1 = 0.01 s, 0 = 0.1 s |
| sv_in | input | 16 | Live set value, four packed BCD digits |
| done | output | 1 | Delay elapsed |
| pv | output | 16 | Present value, four packed BCD digits |
| sv_err | output | 1 | Set value contains an invalid digit |

## Verification
The assertions take for granted that en, clr, fast and sv_in change only between clock edges. They also assume that fast is not switched during a run in a way that would shorten a period that is already under way. For this reason the prescaler bound check covers only the largest limit. The bench changes every input at the falling edge and changes fast only while the timer is idle. Invalid set values are applied only while en is low, so the monotonic-count check never sees a set value rejected in the middle of a run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIG = 4;
  typedef logic [4*DIG-1:0] bcd_t;

  function automatic bcd_t bcd_dec(input bcd_t v);
    bcd_t r;
    logic br;
    r  = v;
    br = 1'b1;
    for (int i = 0; i < DIG; i++) begin
      if (br) begin
        if (r[4*i +: 4] == 4'd0) begin
          r[4*i +: 4] = 4'd9;
        end else begin
          r[4*i +: 4] = r[4*i +: 4] - 4'd1;
          br = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic bcd_ok(input bcd_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIG; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CLK_PER_CENTI = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int LIM_SLOW = CLK_PER_CENTI * 10;
  localparam int W        = (LIM_SLOW > 1) ? $clog2(LIM_SLOW) : 1;
  localparam logic [W-1:0] TOP_FAST = W'(CLK_PER_CENTI - 1);
  localparam logic [W-1:0] TOP_SLOW = W'(LIM_SLOW - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] top;

  always_comb begin
    top  = fast ? TOP_FAST : TOP_SLOW;
    tick = run && (cnt_q >= top);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP_SLOW);
  // R8
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/tmr_bcd_down.sv
module tmr_bcd_down
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  bcd_t load_val,
  output bcd_t pv,
  output logic done
);
  bcd_t pv_d;
  logic done_d;

  always_comb begin
    pv_d   = pv;
    done_d = done;
    if (!run) begin
      pv_d   = load_val;
      done_d = 1'b0;
    end else if (tick) begin
      if (pv <= bcd_t'(1)) begin
        pv_d   = '0;
        done_d = 1'b1;
      end else begin
        pv_d = bcd_dec(pv);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv   <= '0;
      done <= 1'b0;
    end else begin
      pv   <= pv_d;
      done <= done_d;
    end
  end

  // R5
  pv_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(pv));
  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> (pv <= $past(pv)));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run) |=> (done && pv == '0));
  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/bcd_ondelay_timer.sv
module bcd_ondelay_timer
  import tmr_pkg::*;
#(
  parameter int   CLK_PER_CENTI = 500000,
  parameter bit   SV_LIVE       = 1'b1,
  parameter bcd_t SV_FIXED      = 16'h0050
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        clr,
  input  logic        fast,
  input  logic [15:0] sv_in,
  output logic        done,
  output logic [15:0] pv,
  output logic        sv_err
);
  logic [1:0] rs_q;
  logic       rst_s;
  bcd_t       sv_sel, load_val;
  logic       bad, run, tick, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  generate
    if (SV_LIVE) begin : g_live
      assign sv_sel = sv_in;
    end else begin : g_fixed
      assign sv_sel = SV_FIXED;
    end
  endgenerate

  always_comb begin
    bad      = !bcd_ok(sv_sel);
    run      = en && !clr && !bad;
    load_val = bad ? '0 : sv_sel;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= bad;
  end
  assign sv_err = err_q;

  tmr_prescale #(.CLK_PER_CENTI(CLK_PER_CENTI)) u_pre (
    .clk(clk), .rst_n(rst_s), .run(run), .fast(fast), .tick(tick)
  );

  tmr_bcd_down u_cnt (
    .clk(clk), .rst_n(rst_s), .run(run), .tick(tick),
    .load_val(load_val), .pv(pv), .done(done)
  );

  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    sv_err |-> (!done && pv == '0));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!done && pv == '0 && !sv_err));
endmodule

// File: tb/bcd_ondelay_timer_tb.sv
module bcd_ondelay_timer_tb;
  localparam int CPT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, fast = 1'b1;
  logic [15:0] sv_in = 16'h0000;
  logic done, sv_err, done2, sv_err2;
  logic [15:0] pv, pv2;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  bcd_ondelay_timer #(.CLK_PER_CENTI(CPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .fast(fast),
    .sv_in(sv_in), .done(done), .pv(pv), .sv_err(sv_err));

  bcd_ondelay_timer #(.CLK_PER_CENTI(CPT), .SV_LIVE(1'b0), .SV_FIXED(16'h0003)) u_fix (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .fast(fast),
    .sv_in(sv_in), .done(done2), .pv(pv2), .sv_err(sv_err2));

  function automatic logic [15:0] i2b(input int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input int s, input bit f);
    int lim;
    lim  = f ? CPT : CPT * 10;
    en   = 1'b0;
    fast = f;
    sv_in = i2b(s);
    edges(1);
    chk("R2 pv idle", pv, i2b(s));
    chk("R2 done idle", done, 0);
    en = 1'b1;
    if (s == 0) begin
      edges(lim - 1);
      chk("R6 early", done, 0);
      edges(1);
      chk("R6 done", done, 1);
    end else begin
      for (int k = 1; k < s; k++) begin
        edges(lim);
        chk("R5 step", pv, i2b(s - k));
      end
      edges(lim - 1);
      chk(f ? "R3 early" : "R4 early", done, 0);
      edges(1);
      chk(f ? "R3 done" : "R4 done", done, 1);
      chk("R5 zero", pv, 0);
    end
    edges(3 * lim);
    chk("R7 hold done", done, 1);
    chk("R7 hold pv", pv, 0);
    en = 1'b0;
    edges(1);
    chk("R9 done", done, 0);
    chk("R9 pv", pv, i2b(s));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    sv_in = 16'h0007;
    #5;
    edges(2);
    // R1
    chk("R1 done", done, 0);
    chk("R1 pv", pv, 0);
    chk("R1 err", sv_err, 0);
    rst_n = 1'b1;
    edges(3);

    for (int s = 0; s <= 20; s++) run_case(s, 1'b1);
    run_case(100, 1'b1);
    run_case(1000, 1'b1);
    run_case(9999, 1'b1);
    run_case(0, 1'b0);
    run_case(1, 1'b0);
    run_case(2, 1'b0);
    run_case(5, 1'b0);

    // R8
    fast = 1'b1; sv_in = i2b(5); en = 1'b0;
    edges(1);
    en = 1'b1;
    edges(5);
    chk("R8 before clr", pv, i2b(3));
    clr = 1'b1;
    edges(1);
    chk("R8 pv reload", pv, i2b(5));
    chk("R8 done low", done, 0);
    clr = 1'b0;
    edges(5 * CPT - 1);
    chk("R8 early", done, 0);
    edges(1);
    chk("R8 done", done, 1);
    en = 1'b0;
    edges(1);

    // R10
    sv_in = i2b(5);
    edges(1);
    en = 1'b1;
    edges(CPT);
    chk("R10 first", pv, i2b(4));
    sv_in = i2b(9);
    edges(CPT);
    chk("R10 ignored", pv, i2b(3));
    edges(3 * CPT);
    chk("R10 done", done, 1);
    en = 1'b0;
    edges(1);
    chk("R10 next run", pv, i2b(9));

    // R11
    sv_in = 16'h00A5;
    edges(1);
    chk("R11 err", sv_err, 1);
    chk("R11 pv", pv, 0);
    en = 1'b1;
    edges(10);
    chk("R11 no count", done, 0);
    chk("R11 pv hold", pv, 0);
    en = 1'b0;
    sv_in = 16'h9000;
    edges(1);
    chk("R11 err clear", sv_err, 0);
    sv_in = 16'h000F;
    edges(1);
    chk("R11 low digit", sv_err, 1);

    // R12
    sv_in = 16'h0050;
    edges(1);
    chk("R12 fixed pv", pv2, 16'h0003);
    en = 1'b1;
    edges(3 * CPT - 1);
    chk("R12 early", done2, 0);
    edges(1);
    chk("R12 done", done2, 1);
    en = 1'b0;
    edges(1);

    finish_run();
  end
endmodule